// File: doc/BRIEF.md
# Predicate Shadow Distribution Unit

This block is the predicate functional unit that stands beside a row of arithmetic functional units held under shadow. For one vector operation it takes a single copy of an integer predicate register value, converts it into a per-lane enable mask, and resolves every lane's shadow. A lane whose mask bit is set receives a success pulse and may commit. A lane whose bit is clear receives a cancel pulse and its operation is dropped. Because the register is read only once and its bits are fanned out here, the arithmetic units never need their own copy of the predicate.

There are four ways to form the mask. The all-enabled mode ignores the register. The direct mode uses the register bits as they are. The inverted mode uses the complement of the register bits. The single-lane mode treats the register as a lane number and decodes it to a one-hot mask. The vector length caps the active lanes: a lane at or above it is always cancelled. A lane number in single-lane mode that names no existing lane gives an empty mask and raises a range error pulse.

Top module: `pred_shadow_unit`

## Requirements
- R1: While reset is asserted, and in any cycle not preceded by a strobe, `shadow_ok_o`, `shadow_cancel_o` and `range_err_o` are all zero. A strobe given during reset produces no pulse.
- R2: Mode 2'b00 (all enabled): every lane below the effective vector length succeeds, and `pred_i` has no effect on any output.
- R3: Mode 2'b01 (direct): lane i succeeds exactly when bit i of `pred_i` is 1 and i is below the effective vector length. Bits of `pred_i` at or above LANES are ignored.
- R4: Mode 2'b10 (inverted): lane i succeeds exactly when bit i of `pred_i` is 0 and i is below the effective vector length.
- R5: Mode 2'b11 (single lane): when the value r of `pred_i` is below LANES, only lane r may succeed, and it does so when r is below the effective vector length. `range_err_o` stays low.
- R6: Mode 2'b11 with r at or above LANES: every lane is cancelled and `range_err_o` pulses in the same cycle as the cancels. `range_err_o` never pulses in the other modes.
- R7: Lanes at or above `vl_i` are always cancelled. A `vl_i` above LANES acts as LANES, and a `vl_i` of 0 cancels every lane.
- R8: Pulses appear exactly one cycle after `pred_vld_i` is high and last one cycle. In that cycle each lane gets exactly one of success or cancel. Strobes on consecutive cycles give pulses on consecutive cycles.
- R9: No lane ever sees success and cancel together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| mode_i | input | 2 | Mask mode: 00 all enabled, 01 direct, 10 inverted, 11 single lane |
| pred_i | input | REG_W | Predicate register value, read once per operation |
| pred_vld_i | input | 1 | Strobe: the predicate value, mode and vector length are valid |
| vl_i | input | VL_W | Vector length (number of active lanes) |
| shadow_ok_o | output | LANES | Per-lane shadow success pulse |
| shadow_cancel_o | output | LANES | Per-lane shadow cancel pulse |
| range_err_o | output | 1 | Pulse: the single-lane index named no existing lane |

## Verification
The bench sweeps every low-byte predicate pattern in the direct and inverted modes, with random upper bits, against every vector length from 0 to beyond the lane count. This catches a design that swaps polarity, lets upper register bits leak into the mask, or fails to clamp or cancel lanes past the vector length. Single-lane mode is swept through every index, across the lane-count boundary and up to large values. A decoder that wraps the index modulo the lane count would wrongly grant a lane there, and a missing or misplaced error pulse would show. All-enabled mode is fed changing predicate values to prove the register is ignored. Back-to-back strobes, idle gaps and strobes held during reset expose pulses that stretch, drop or leak out of reset.

// File: rtl/pshd_pkg.sv
package pshd_pkg;
  typedef enum logic [1:0] {
    PM_ALL    = 2'b00,
    PM_DIRECT = 2'b01,
    PM_INVERT = 2'b10,
    PM_SINGLE = 2'b11
  } pmode_e;
endpackage

// File: rtl/pshd_rst_sync.sv
module pshd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pshd_mask_decode.sv
module pshd_mask_decode
  import pshd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int REG_W = 16
) (
  input  pmode_e             mode,
  input  logic [REG_W-1:0]   pred,
  output logic [LANES-1:0]   mask,
  output logic               range_err
);
  logic [LANES-1:0] onehot;
  logic             in_range;

  // binary-to-unary decode, one comparator per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [REG_W-1:0] LANE_IDX = REG_W'(g);
    assign onehot[g] = (pred == LANE_IDX);
  end

  assign in_range = |onehot;

  always_comb begin
    mask      = '0;
    range_err = 1'b0;
    unique case (mode)
      PM_ALL:    mask = '1;
      PM_DIRECT: mask = pred[LANES-1:0];
      PM_INVERT: mask = ~pred[LANES-1:0];
      PM_SINGLE: begin
        mask      = onehot;
        range_err = ~in_range;
      end
      default:   mask = '0;
    endcase
  end
endmodule

// File: rtl/pshd_vl_limit.sv
module pshd_vl_limit #(
  parameter int LANES = 8,
  parameter int VL_W  = $clog2(LANES + 1)
) (
  input  logic [VL_W-1:0]  vl,
  output logic [LANES-1:0] active
);
  // thermometer: lane g is live while g < vl (vl above LANES saturates)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [VL_W-1:0] LANE_IDX = VL_W'(g);
    assign active[g] = (vl > LANE_IDX);
  end
endmodule

// File: rtl/pshd_resolve.sv
module pshd_resolve #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [LANES-1:0] grant,
  input  logic             err,
  output logic [LANES-1:0] ok,
  output logic [LANES-1:0] cancel,
  output logic             err_pulse
);
  logic             fire_q, fire_d;
  logic [LANES-1:0] grant_q, grant_d;
  logic             err_q, err_d;

  always_comb begin
    fire_d  = strobe;
    grant_d = grant_q;
    err_d   = err_q;
    if (strobe) begin
      grant_d = grant;
      err_d   = err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q  <= 1'b0;
      grant_q <= '0;
      err_q   <= 1'b0;
    end else begin
      fire_q  <= fire_d;
      grant_q <= grant_d;
      err_q   <= err_d;
    end
  end

  assign ok        = {LANES{fire_q}} & grant_q;
  assign cancel    = {LANES{fire_q}} & ~grant_q;
  assign err_pulse = fire_q & err_q;
endmodule

// File: rtl/pred_shadow_unit.sv
module pred_shadow_unit
  import pshd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int REG_W = 16,
  parameter int VL_W  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [REG_W-1:0] pred_i,
  input  logic             pred_vld_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic [LANES-1:0] shadow_ok_o,
  output logic [LANES-1:0] shadow_cancel_o,
  output logic             range_err_o
);
  logic             rst_sync_n;
  logic [LANES-1:0] pred_mask;
  logic [LANES-1:0] live_lanes;
  logic [LANES-1:0] grant;
  logic             dec_err;
  pmode_e           mode;

  assign mode = pmode_e'(mode_i);

  pshd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pshd_mask_decode #(.LANES(LANES), .REG_W(REG_W)) u_dec (
    .mode(mode), .pred(pred_i), .mask(pred_mask), .range_err(dec_err)
  );

  pshd_vl_limit #(.LANES(LANES), .VL_W(VL_W)) u_vl (
    .vl(vl_i), .active(live_lanes)
  );

  assign grant = pred_mask & live_lanes;

  pshd_resolve #(.LANES(LANES)) u_res (
    .clk(clk), .rst_n(rst_sync_n), .strobe(pred_vld_i),
    .grant(grant), .err(dec_err),
    .ok(shadow_ok_o), .cancel(shadow_cancel_o), .err_pulse(range_err_o)
  );
endmodule

// File: rtl/pred_shadow_chk.sv
module pred_shadow_chk #(
  parameter int LANES = 8,
  parameter int REG_W = 16,
  parameter int VL_W  = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic [REG_W-1:0] pred_i,
  input logic             pred_vld_i,
  input logic [VL_W-1:0]  vl_i,
  input logic [LANES-1:0] shadow_ok_o,
  input logic [LANES-1:0] shadow_cancel_o,
  input logic             range_err_o
);
  function automatic logic [LANES-1:0] live_of(input logic [VL_W-1:0] v);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = (int'(v) > k);
    return r;
  endfunction

  // R9: success and cancel exclusive per lane
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_ok_o & shadow_cancel_o) == '0);

  // R8: every lane resolved in the cycle after a strobe
  a_r8_all_resolved: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld_i |=> ($countones(shadow_ok_o | shadow_cancel_o) == LANES));

  // R8 / R1: quiet when no strobe preceded
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_vld_i |=> ((shadow_ok_o | shadow_cancel_o) == '0 && !range_err_o));

  // R7: nothing beyond the vector length succeeds
  a_r7_vl_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld_i |=> ((shadow_ok_o & ~live_of($past(vl_i))) == '0));

  // R5: single-lane mode grants at most one lane
  a_r5_single_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_vld_i && mode_i == 2'b11) |=> $onehot0(shadow_ok_o));

  // R6: range error implies no success
  a_r6_err_no_ok: assert property (@(posedge clk) disable iff (!rst_n)
    range_err_o |-> (shadow_ok_o == '0));

  // R6: range error only follows a single-lane strobe
  a_r6_err_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_vld_i && mode_i != 2'b11) |=> !range_err_o);

  // R2: all-enabled mode grants every live lane
  a_r2_all_live: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_vld_i && mode_i == 2'b00) |=> (shadow_ok_o == live_of($past(vl_i))));
endmodule

bind pred_shadow_unit pred_shadow_chk #(.LANES(LANES), .REG_W(REG_W), .VL_W(VL_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .mode_i(mode_i), .pred_i(pred_i),
  .pred_vld_i(pred_vld_i), .vl_i(vl_i), .shadow_ok_o(shadow_ok_o),
  .shadow_cancel_o(shadow_cancel_o), .range_err_o(range_err_o)
);

// File: tb/pred_shadow_unit_tb_top.sv
`timescale 1ns/1ps
module pred_shadow_unit_tb_top;
  localparam int LANES = 8;
  localparam int REG_W = 16;
  localparam int VL_W  = $clog2(LANES + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_i = '0;
  logic [REG_W-1:0] pred_i = '0;
  logic             pred_vld_i = 1'b0;
  logic [VL_W-1:0]  vl_i = '0;
  logic [LANES-1:0] shadow_ok_o;
  logic [LANES-1:0] shadow_cancel_o;
  logic             range_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pred_shadow_unit #(.LANES(LANES), .REG_W(REG_W), .VL_W(VL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pred_i(pred_i),
    .pred_vld_i(pred_vld_i), .vl_i(vl_i), .shadow_ok_o(shadow_ok_o),
    .shadow_cancel_o(shadow_cancel_o), .range_err_o(range_err_o)
  );

  task automatic check(input string req, input logic [LANES-1:0] ok,
                       input logic [LANES-1:0] cn, input logic er);
    checks++;
    if (shadow_ok_o !== ok || shadow_cancel_o !== cn || range_err_o !== er) begin
      failures++;
      $display("FAIL %s: got ok=%b cancel=%b err=%b, expected ok=%b cancel=%b err=%b",
               req, shadow_ok_o, shadow_cancel_o, range_err_o, ok, cn, er);
    end
  endtask

  // expected grant computed from the requirements
  function automatic logic [LANES-1:0] exp_grant(input logic [1:0] m,
      input logic [REG_W-1:0] p, input int vl);
    logic [LANES-1:0] msk;
    logic [LANES-1:0] lim;
    int v;
    case (m)
      2'b00: msk = '1;
      2'b01: msk = p[LANES-1:0];
      2'b10: msk = ~p[LANES-1:0];
      default: msk = (int'(p) < LANES) ? LANES'(1 << int'(p)) : '0;
    endcase
    v = (vl > LANES) ? LANES : vl;
    lim = LANES'((16'd1 << v) - 16'd1);
    return msk & lim;
  endfunction

  // drive at a falling edge, sample at the next falling edge
  task automatic run_op(input string req, input logic [1:0] m,
                        input logic [REG_W-1:0] p, input int vl);
    logic [LANES-1:0] g;
    logic e;
    mode_i = m; pred_i = p; vl_i = VL_W'(vl); pred_vld_i = 1'b1;
    g = exp_grant(m, p, vl);
    e = (m == 2'b11) && (int'(p) >= LANES);
    @(negedge clk);
    pred_vld_i = 1'b0;
    check(req, g, ~g, e);
  endtask

  task automatic idle_check(input string req);
    pred_i = REG_W'($urandom); mode_i = 2'($urandom);
    @(negedge clk);
    check(req, '0, '0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    // R1: strobes held during reset yield nothing
    @(negedge clk);
    mode_i = 2'b00; vl_i = VL_W'(LANES); pred_vld_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, '0, 1'b0);
    pred_vld_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", '0, '0, 1'b0);

    // R2: all-enabled ignores pred
    for (int vl = 0; vl <= 10; vl++)
      for (int k = 0; k < 8; k++)
        run_op("R2 all enabled", 2'b00, REG_W'($urandom), vl);
    idle_check("R1 idle");

    // R3 / R4 / R7: full low-byte sweep, random upper bits, every VL
    for (int vl = 0; vl < (1 << VL_W); vl++)
      for (int p = 0; p < 256; p++) begin
        run_op("R3 direct", 2'b01, {8'($urandom), 8'(p)}, vl);
        run_op("R4 inverted", 2'b10, {8'($urandom), 8'(p)}, vl);
      end
    idle_check("R8 idle");

    // R5 / R6 / R7: single lane across the boundary
    for (int vl = 0; vl < (1 << VL_W); vl++) begin
      for (int r = 0; r < 20; r++)
        run_op((r < LANES) ? "R5 single lane" : "R6 range", 2'b11, REG_W'(r), vl);
      run_op("R6 range high", 2'b11, 16'hFFFF, vl);
      run_op("R6 range wrap", 2'b11, 16'h0102, vl);
      idle_check("R8 gap");
    end

    // R8: mixed back-to-back strobes then idle
    for (int k = 0; k < 200; k++)
      run_op("R8 back-to-back", 2'($urandom), REG_W'($urandom % 12), int'($urandom % 11));
    idle_check("R8 final idle");
    idle_check("R9 final idle");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule